// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This unit holds the predicate that decides whether a small processor's retiring instructions may commit their side effects. A dedicated condition instruction carries a 3-bit code; when it retires, the unit evaluates that code once against the current zero and sign flags and latches the outcome as the execute-enable state. That state then gates every later instruction until another condition instruction retires. It stays latched however the flags move, and however many instructions retire in the meantime.

Register, memory and program-counter write requests pass through a per-port gate. A request is granted only when its instruction retires while execute-enable is high. A conditional jump is written as a condition instruction, then an immediate load into the temporary register, then a move of the temporary register into the program-counter register, then an always-execute condition. The move's program-counter write is granted only if the condition held. The condition instruction itself is never suppressed, so the always-execute code can re-enable execution from any state.

Top module: `pred_cond_unit`

## Requirements
- R1: After synchronous active-low reset, exec_en is 1, which is the always-execute state.
- R2: A condition instruction is taken only in a cycle where cond_valid and retire are both 1. In that case exec_en takes the evaluated result on the following clock edge.
- R3: Code 0 (equal) evaluates to flag_zero, and code 1 (not equal) evaluates to the inverse of flag_zero.
- R4: Code 2 (less) evaluates to flag_sign. Code 3 (less or equal) evaluates to flag_sign OR flag_zero. Code 4 (greater) evaluates to the case where both flags are clear. Code 5 (greater or equal) evaluates to the inverse of flag_sign.
- R5: Code 6 (always) sets exec_en to 1, and code 7 (never) sets it to 0, whatever the flags are.
- R6: exec_en keeps its value on every edge where no condition instruction is taken, whatever the flags do and whether or not other instructions retire.
- R7: A condition instruction is taken even while exec_en is 0.
- R8: cond_valid asserted while retire is 0 has no effect on exec_en.
- R9: Each wr_grant bit equals its wr_req bit ANDed with retire and with the current exec_en. Bit 0 is the register port, bit 1 the memory port and bit 2 the program-counter port.
- R10: In a conditional-jump sequence, the program-counter write is granted exactly when the condition evaluated true. After the closing always-execute code, all writes are granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_zero | input | 1 | Zero flag from the ALU |
| flag_sign | input | 1 | Sign flag from the ALU |
| retire | input | 1 | An instruction retires this cycle |
| cond_valid | input | 1 | The retiring instruction is a condition instruction |
| cond_code | input | 3 | Condition code |
| wr_req | input | 3 | Write requests: register, memory, program counter |
| exec_en | output | 1 | Execute-enable state |
| wr_grant | output | 3 | Gated write enables |

## Verification
The assertions assume that the flags and the condition fields are driven to known values whenever retire is high. They also assume that a condition instruction raises no write request of its own. Beyond that, they expect the predicate to change only on a taken condition instruction. The stimulus is drawn from $urandom with a fixed seed. It keeps wr_req at zero whenever cond_valid is set, and keeps every input free of unknown values. Directed sequences cover the jump idiom, re-enabling from the disabled state, and condition strobes issued without retire.

// File: rtl/pred_cond_pkg.sv
// Package: shared condition-code type and widths for the predicate unit.
// Assumes the 3-bit code order below is fixed by the instruction encoding.
package pred_cond_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_LT  = 3'd2,
        CC_LE  = 3'd3,
        CC_GT  = 3'd4,
        CC_GE  = 3'd5,
        CC_ALW = 3'd6,
        CC_NEV = 3'd7
    } cond_code_e;
endpackage

// File: rtl/pred_cond_eval.sv
// Module: pred_cond_eval
// Combinational evaluation of one condition code against the zero and sign flags.
// Assumes signed results: sign set means negative, zero set means equal.
module pred_cond_eval
    import pred_cond_pkg::*;
(
    input  logic              flag_zero,
    input  logic              flag_sign,
    input  logic [CODE_W-1:0] code,
    output logic              result
);
    // Select the predicate named by the code.
    always_comb begin
        unique case (cond_code_e'(code))
            CC_EQ:   result = flag_zero;
            CC_NE:   result = ~flag_zero;
            CC_LT:   result = flag_sign;
            CC_LE:   result = flag_sign | flag_zero;
            CC_GT:   result = ~flag_sign & ~flag_zero;
            CC_GE:   result = ~flag_sign;
            CC_ALW:  result = 1'b1;
            CC_NEV:  result = 1'b0;
            default: result = 1'b1;
        endcase
    end
endmodule

// File: rtl/pred_cond_state.sv
// Module: pred_cond_state
// Holds the execute-enable predicate; loads it only when a condition instruction retires.
// Assumes the take strobe is already qualified by retire; never gated by its own output.
module pred_cond_state
    import pred_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              next_en,
    input  logic [CODE_W-1:0] code,
    input  logic              flag_zero,
    output logic              exec_en
);
    // Latch the evaluated predicate on a taken condition instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exec_en <= 1'b1;
        else if (take)
            exec_en <= next_en;
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(exec_en));
    // R5
    always_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && code == CC_ALW) |=> exec_en);
    // R5
    never_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && code == CC_NEV) |=> !exec_en);
    // R3
    eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && code == CC_EQ) |=> exec_en == $past(flag_zero));
endmodule

// File: rtl/pred_wr_gate.sv
// Module: pred_wr_gate
// Per-port gating of write requests by retire and the execute-enable predicate.
// Assumes requests are meaningful only in the retire cycle of their instruction.
module pred_wr_gate #(
    parameter int NUM_WR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  logic              exec_en,
    input  logic [NUM_WR-1:0] wr_req,
    output logic [NUM_WR-1:0] wr_grant
);
    for (genvar i = 0; i < NUM_WR; i++) begin : g_port
        // Grant one port when its instruction retires while execution is enabled.
        always_comb wr_grant[i] = wr_req[i] & retire & exec_en;
    end

    // R9
    grant_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_grant) |-> (exec_en && retire));
    // R9
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_grant & ~wr_req) == '0);
endmodule

// File: rtl/pred_cond_unit.sv
// Module: pred_cond_unit (top)
// Persistent predication: a retiring condition instruction sets the execute-enable
// state, which gates the write ports of all later instructions until the next one.
// Assumes flags come from earlier instructions and a condition instruction has no writes.
module pred_cond_unit
    import pred_cond_pkg::*;
#(
    parameter int NUM_WR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_zero,
    input  logic              flag_sign,
    input  logic              retire,
    input  logic              cond_valid,
    input  logic [CODE_W-1:0] cond_code,
    input  logic [NUM_WR-1:0] wr_req,
    output logic              exec_en,
    output logic [NUM_WR-1:0] wr_grant
);
    logic take;
    logic eval_res;

    // Qualify the condition strobe by retire; independent of exec_en (R7).
    always_comb take = cond_valid & retire;

    pred_cond_eval u_eval (
        .flag_zero (flag_zero),
        .flag_sign (flag_sign),
        .code      (cond_code),
        .result    (eval_res)
    );

    pred_cond_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .next_en   (eval_res),
        .code      (cond_code),
        .flag_zero (flag_zero),
        .exec_en   (exec_en)
    );

    pred_wr_gate #(.NUM_WR(NUM_WR)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire   (retire),
        .exec_en  (exec_en),
        .wr_req   (wr_req),
        .wr_grant (wr_grant)
    );

    // R8
    no_retire_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && !retire) |=> $stable(exec_en));
    // R7
    reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en && retire && cond_valid && cond_code == CC_ALW) |=> exec_en);
    // R4
    ge_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && cond_valid && cond_code == CC_GE) |=> exec_en == !$past(flag_sign));
endmodule

// File: tb/pred_cond_unit_bench.sv
module pred_cond_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fz = 1'b0, fs = 1'b0, ret = 1'b0, cv = 1'b0;
    logic [2:0] code = 3'd0;
    logic [NW-1:0] req = '0;
    logic exec_en;
    logic [NW-1:0] grant;

    int total = 0;
    int bad = 0;
    logic model_en = 1'b1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_cond_unit #(.NUM_WR(NW)) u_pred_cond_unit (
        .clk(clk), .rst_n(rst_n), .flag_zero(fz), .flag_sign(fs),
        .retire(ret), .cond_valid(cv), .cond_code(code),
        .wr_req(req), .exec_en(exec_en), .wr_grant(grant)
    );

    // Expected predicate for a code: R3, R4, R5.
    function automatic logic eval_ref(input logic [2:0] c, input logic z, input logic s);
        case (c)
            3'd0: return z;
            3'd1: return !z;
            3'd2: return s;
            3'd3: return s || z;
            3'd4: return !s && !z;
            3'd5: return !s;
            3'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // Drive one cycle, check combinational grants and the held state, then advance the model.
    task automatic step(input logic r, input logic c, input logic [2:0] cc,
                        input logic z, input logic s, input logic [NW-1:0] w,
                        input string tag);
        @(negedge clk);
        ret = r; cv = c; code = cc; fz = z; fs = s; req = w;
        #1;
        chk({tag, " exec_en"}, 32'(exec_en), 32'(model_en));
        chk("R9 grant", 32'(grant), 32'(w & {NW{r & model_en}}));
        @(posedge clk);
        if (r && c) model_en = eval_ref(cc, z, s);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset enable", 32'(exec_en), 32'd1);

        // R3 R4 R5: every code against every flag pair, re-enabling after each
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 4; f++) begin
                step(1, 1, 3'(cc), f[0], f[1], '0, "R2 load");
                step(1, 0, 3'd0, 1'b0, 1'b0, 3'b111, "R3 R4 R5 result");
                step(1, 1, 3'd6, 1'b0, 1'b0, '0, "R5 always");
            end
        end

        // R7: disable, then re-enable while disabled
        step(1, 1, 3'd7, 0, 0, '0, "R5 never");
        step(1, 0, 3'd0, 1, 1, 3'b111, "R6 hold off");
        step(1, 1, 3'd6, 0, 0, '0, "R7 reenable");
        step(1, 0, 3'd0, 0, 0, 3'b111, "R7 enabled");

        // R8: strobe without retire ignored
        step(0, 1, 3'd7, 0, 0, '0, "R8 no retire");
        step(1, 0, 3'd0, 0, 0, 3'b101, "R8 still on");

        // R10: conditional jump, taken then not taken
        for (int t = 0; t < 2; t++) begin
            step(1, 1, 3'd0, t == 0, 0, '0, "R10 cond eq");
            step(1, 0, 3'd0, 0, 1, 3'b001, "R10 load temp");
            step(1, 0, 3'd0, 1, 0, 3'b101, "R10 move pc");
            step(1, 1, 3'd6, 0, 0, '0, "R10 close");
            step(1, 0, 3'd0, 0, 0, 3'b111, "R10 after");
        end

        // R6: random mix; condition instructions carry no write requests
        for (int i = 0; i < 3000; i++) begin
            logic r, c;
            logic [NW-1:0] w;
            r = $urandom_range(0, 3) != 0;
            c = $urandom_range(0, 4) == 0;
            w = c ? '0 : NW'($urandom);
            step(r, c, 3'($urandom), 1'($urandom), 1'($urandom), w, "R6 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule